// File: doc/BRIEF.md
# Two-Source Clock Fanout with Falling-Edge Gate

This block takes two candidate clocks, routes the one named by a select input, and drives that clock unchanged onto five matching copies. A run request (active low) is captured by a flop clocked on the falling edge of the routed clock. The flop's output gates every copy. Gating changes only while the routed clock is low, so no copy ever shows a clipped high phase. While the gate is closed, all copies rest at zero.

Each clock input has a companion flag that marks it as not connected. A flagged source reads as a constant zero, so if it is the routed one the copies stay low. A synchronous, active-high reset closes the gate. Reset is sampled on the same falling edges, and the gate stays shut until a later falling edge finds the run request asserted. A status output reports the state of the gate flop.

Top module: `clk_fanout_gated`

## Requirements
- R1: With `clk_sel` = 0 the copies follow `clk_src[0]`; with `clk_sel` = 1 they follow `clk_src[1]` (gate open, source not flagged).
- R2: All bits of `clk_out` carry the same value at all times.
- R3: `en_n` is active low: a sampled 0 opens the gate and a sampled 1 closes it.
- R4: `en_n` is sampled only on a falling edge of the routed clock. A change seen while that clock is high leaves `enabled` and `clk_out` as they were until the next falling edge. `enabled` equals the inverse of the last sampled `en_n`.
- R5: While `enabled` is 0, every bit of `clk_out` is 0.
- R6: Every high pulse on `clk_out` lasts exactly one full high phase of the routed clock.
- R7: `clk_open[i]` = 1 makes source i read as constant 0. Flagging the routed source holds the copies low. Flagging the other source has no effect on the copies.
- R8: `rst` = 1 at a falling edge of the routed clock forces `enabled` to 0. After reset is released, the gate opens only at a falling edge that samples `en_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous reset, active high, sampled on routed-clock falling edges |
| clk_src | input | NUM_SRC | Candidate clocks, bit i is source i |
| clk_open | input | NUM_SRC | Bit i marks source i as not connected |
| clk_sel | input | SEL_W | Index of the source to route |
| en_n | input | 1 | Run request, active low |
| clk_out | output | NUM_OUT | Gated copies of the routed clock |
| enabled | output | 1 | Current state of the gate flop |

## Verification
The checks assume that `en_n` and `rst` never change at a falling edge of the routed clock. They also assume that `clk_sel` changes only while the gate is closed, and that a connection flag on the routed source changes only while that clock is low. The stimulus follows these rules. It moves `en_n` 1.5 ns or 3.5 ns after a rising edge of the routed clock, switches sources only after closing the gate, and toggles flags just after a falling edge. All output samples fall on half-nanosecond offsets, where no clock edge occurs.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;

  // Index of each clock source in the clk_src / clk_open vectors
  typedef enum logic {
    SRC_PRIMARY   = 1'b0,
    SRC_SECONDARY = 1'b1
  } src_idx_e;

  // Bits needed to address n sources (never less than one)
  function automatic int sel_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cfo_input_cond.sv
module cfo_input_cond #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] clk_raw,
  input  logic [NUM_SRC-1:0] src_absent,
  output logic [NUM_SRC-1:0] clk_clean
);
  // An absent source resolves to a steady low level
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cond
    assign clk_clean[g] = clk_raw[g] & ~src_absent[g];
  end
endmodule

// File: rtl/cfo_src_mux.sv
module cfo_src_mux #(
  parameter int NUM_SRC = 2,
  parameter int SEL_W   = 1
) (
  input  logic [NUM_SRC-1:0] clk_clean,
  input  logic [SEL_W-1:0]   sel,
  output logic               clk_routed
);
  // Out-of-range index routes nothing (low)
  always_comb begin
    clk_routed = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) clk_routed = clk_clean[i];
    end
  end
endmodule

// File: rtl/cfo_enable_sync.sv
module cfo_enable_sync (
  input  logic clk_routed,
  input  logic rst,
  input  logic run_req_n,
  output logic run_q
);
  // Captured while the routed clock falls, so the gate only moves
  // during the low phase
  always_ff @(negedge clk_routed) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= ~run_req_n;
  end
endmodule

// File: rtl/cfo_fanout_gate.sv
module cfo_fanout_gate #(
  parameter int NUM_OUT = 5
) (
  input  logic               clk_routed,
  input  logic               run_q,
  output logic [NUM_OUT-1:0] clk_copies
);
  // One process drives the whole vector so all copies move together
  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) begin
      clk_copies[i] = clk_routed & run_q;
    end
  end
endmodule

// File: rtl/clk_fanout_gated.sv
module clk_fanout_gated
  import clk_fanout_pkg::*;
#(
  parameter  int NUM_SRC = 2,
  parameter  int NUM_OUT = 5,
  localparam int SEL_W   = sel_bits(NUM_SRC)
) (
  input  logic               rst,
  input  logic [NUM_SRC-1:0] clk_src,
  input  logic [NUM_SRC-1:0] clk_open,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               en_n,
  output logic [NUM_OUT-1:0] clk_out,
  output logic               enabled
);

  logic [NUM_SRC-1:0] clk_clean;
  logic               clk_muxed;
  logic               gate_q;

  cfo_input_cond #(.NUM_SRC(NUM_SRC)) u_cond (
    .clk_raw    (clk_src),
    .src_absent (clk_open),
    .clk_clean  (clk_clean)
  );

  cfo_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .clk_clean  (clk_clean),
    .sel        (clk_sel),
    .clk_routed (clk_muxed)
  );

  cfo_enable_sync u_gate_ff (
    .clk_routed (clk_muxed),
    .rst        (rst),
    .run_req_n  (en_n),
    .run_q      (gate_q)
  );

  cfo_fanout_gate #(.NUM_OUT(NUM_OUT)) u_fanout (
    .clk_routed (clk_muxed),
    .run_q      (gate_q),
    .clk_copies (clk_out)
  );

  assign enabled = gate_q;

endmodule

// File: rtl/clk_fanout_gated_chk.sv
module clk_fanout_gated_chk #(
  parameter int NUM_OUT = 5
) (
  input logic               rst,
  input logic               clk_muxed,
  input logic               en_n,
  input logic [NUM_OUT-1:0] clk_out,
  input logic               enabled
);

  // R3
  en_open_chk: assert property (@(negedge clk_muxed) disable iff (rst)
    !en_n |=> enabled);

  // R4
  en_close_chk: assert property (@(negedge clk_muxed) disable iff (rst)
    en_n |=> !enabled);

  // R8
  rst_clear_chk: assert property (@(negedge clk_muxed)
    rst |=> !enabled);

  always_comb begin
    if (!rst) begin
      // R5
      if (!enabled) begin
        off_low_chk: assert (clk_out == '0);
      end
      // R2
      copies_match_chk: assert (clk_out == '0 || clk_out == '1);
    end
  end

endmodule

bind clk_fanout_gated clk_fanout_gated_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .rst       (rst),
  .clk_muxed (clk_muxed),
  .en_n      (en_n),
  .clk_out   (clk_out),
  .enabled   (enabled)
);

// File: tb/clk_fanout_gated_tb.sv
`timescale 1ns/100ps
module clk_fanout_gated_tb;

  localparam int NOUT = 5;

  logic            clk_a = 1'b0;  // 100 MHz source 0
  logic            clk_b = 1'b0;  // ~71 MHz source 1
  logic            rst;
  logic [1:0]      clk_open;
  logic [0:0]      clk_sel;
  logic            en_n;
  logic [NOUT-1:0] clk_out;
  logic            enabled;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  en_exp   = 1'b0;
  bit  done     = 1'b0;

  always #5 clk_a = ~clk_a;
  always #7 clk_b = ~clk_b;

  clk_fanout_gated #(.NUM_SRC(2), .NUM_OUT(NOUT)) u_dut (
    .rst      (rst),
    .clk_src  ({clk_b, clk_a}),
    .clk_open (clk_open),
    .clk_sel  (clk_sel),
    .en_n     (en_n),
    .clk_out  (clk_out),
    .enabled  (enabled)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $realtime);
    end
  endtask

  function automatic logic [NOUT-1:0] exp_out();
    logic src;
    src = clk_sel[0] ? clk_b : clk_a;
    if (clk_open[clk_sel[0]]) src = 1'b0;
    return (en_exp && src) ? '1 : '0;
  endfunction

  // Sample n times at 1 ns spacing (half-ns offsets, away from edges)
  task automatic win(int n, string req);
    for (int k = 0; k < n; k++) begin
      #1;
      chk(clk_out == exp_out(), req, "clk_out", 32'(clk_out), 32'(exp_out()));
      chk(enabled == en_exp, req, "enabled", 32'(enabled), 32'(en_exp));
    end
  endtask

  task automatic src_rise();
    if (clk_sel[0]) @(posedge clk_b); else @(posedge clk_a);
  endtask

  task automatic src_fall();
    if (clk_sel[0]) @(negedge clk_b); else @(negedge clk_a);
  endtask

  // R6: every high pulse is a full high phase of the routed clock
  realtime t_rise;
  bit      rise_seen = 1'b0;
  always @(posedge clk_out[0]) begin
    if (!rst) begin
      t_rise    = $realtime;
      rise_seen = 1'b1;
    end
  end
  always @(negedge clk_out[0]) begin
    if (rise_seen && !done) begin
      realtime w, h;
      w = $realtime - t_rise;
      h = clk_sel[0] ? 7.0 : 5.0;
      chk((w > h - 0.05) && (w < h + 0.05), "R6", "pulse width x10",
          32'($rtoi(w * 10.0)), 32'($rtoi(h * 10.0)));
      rise_seen = 1'b0;
    end
  end

  initial begin
    rst = 1'b1; en_n = 1'b0; clk_sel = 1'b0; clk_open = 2'b00;
    #40.5;
    // R8: reset holds the gate shut even with en_n low
    win(20, "R8");
    src_rise(); #1.5;
    rst = 1'b0;
    chk(enabled == 1'b0, "R8", "enabled after release", 32'(enabled), 0);
    // R4: clock high but no falling edge yet -> still closed
    win(2, "R4");
    src_fall(); #0.5;
    en_exp = 1'b1;
    chk(enabled == 1'b1, "R4", "enabled at falling edge", 32'(enabled), 1);
    // R1: source 0 routed
    win(30, "R1");

    // R4: close request during high phase does not cut the pulse
    src_rise(); #1.5;
    en_n = 1'b1;
    #0.5;
    chk(clk_out == '1, "R4", "still high after close request", 32'(clk_out), 32'('1));
    src_fall(); #0.5;
    en_exp = 1'b0;
    // R5: closed gate keeps everything low
    win(30, "R5");

    // Switch to source 1 while closed
    clk_sel = 1'b1;
    src_rise(); #1.5;
    en_n = 1'b0;
    #0.5;
    chk(clk_out == '0, "R4", "no output before falling edge", 32'(clk_out), 0);
    chk(enabled == 1'b0, "R4", "enabled before falling edge", 32'(enabled), 0);
    src_fall(); #0.5;
    en_exp = 1'b1;
    // R1: source 1 routed; R2 copies all equal
    win(42, "R1");

    // R7: flag the routed source, then the other one
    @(negedge clk_b); #0.5;
    clk_open = 2'b10;
    win(30, "R7");
    @(negedge clk_b); #0.5;
    clk_open = 2'b01;
    win(30, "R7");
    @(negedge clk_b); #0.5;
    clk_open = 2'b00;
    win(14, "R2");

    // R3: sweep sources and request patterns at two phase offsets
    for (int s = 0; s < 2; s++) begin
      src_rise(); #1.5;
      en_n = 1'b1;
      src_fall(); #0.5;
      en_exp = 1'b0;
      clk_sel = s[0];
      for (int k = 0; k < 6; k++) begin
        src_rise();
        if (k % 3 == 2) #3.5; else #1.5;
        en_n = k[0];
        src_fall(); #0.5;
        en_exp = !en_n;
        chk(enabled == en_exp, "R3", "enabled vs en_n", 32'(enabled), 32'(en_exp));
        win(12, "R3");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule